// File: doc/BRIEF.md
# JTAG Host Shift Engine

This block is the host side of a JTAG link. It drives TCK, TMS and TDI toward a target test access port and samples the TDO line that comes back. A controller issues one command at a time. A command either walks the target's TAP state machine or shifts a word of 1 to 32 bits through the selected scan register. Walking commands cover a TAP reset that ends in Run-Test/Idle and moves into Shift-IR or Shift-DR.

A shift command has three per-command options. The first sets the bit order. The second decides whether TMS rises with the last data bit. The third decides whether the engine then walks on to Run-Test/Idle. With these options a long scan chain can be split over several back-to-back transfers, and the last of them closes the shift. The engine returns the bits it captured on TDO, packed so that each captured bit sits at the position of the bit sent in the same TCK cycle.

TCK comes from the system clock through a divider. The divider takes a half-period setting for each command.

Top module: `jtag_shift_master`

## Requirements
- R1: After reset, tck is 0, tms is 1, tdi is 0, busy and done are 0, and rx_data is all zeros.
- R2: A reset command (cmd_op = 1) gives exactly six TCK cycles. TMS is high for the first five and low for the sixth, so the target ends in Run-Test/Idle from any state.
- R3: From Run-Test/Idle, a goto-IR command (cmd_op = 2) gives four TCK cycles with TMS = 1,1,0,0 and ends in Shift-IR. A goto-DR command (cmd_op = 3) gives three TCK cycles with TMS = 1,0,0 and ends in Shift-DR.
- R4: A shift command (cmd_op = 0) sends n = cmd_len_m1 + 1 data bits, one per TCK cycle. With cmd_msb_first = 0, the i-th bit sent is cmd_data[i].
- R5: With cmd_msb_first = 1, the i-th bit sent is cmd_data[n-1-i], so the first bit sent is bit n-1.
- R6: The bit sampled on TDO in data cycle i is stored in rx_data[i] for LSB-first transfers and in rx_data[n-1-i] for MSB-first transfers. Bits n and above read 0.
- R7: With cmd_exit = 1, TMS is high on the last data bit only. With cmd_exit = 0, TMS stays low on every data bit, the target stays in its shift state, and cmd_to_idle has no effect.
- R8: With cmd_exit = 1 and cmd_to_idle = 1, two more TCK cycles follow (TMS 1 then 0) and the target ends in Run-Test/Idle. With cmd_exit = 1 and cmd_to_idle = 0, one more cycle with TMS 1 follows and the target ends in Update.
- R9: TMS and TDI never change while TCK is high. They change only in the cycle where TCK falls, or when a command is accepted with TCK low. TDO is sampled at each falling edge.
- R10: Each TCK phase lasts H system clocks. H is half_div as sampled at command accept, raised to 2 when it is smaller.
- R11: A command is accepted when cmd_valid is high and busy is low. busy rises in the next cycle and drops in the cycle of the last falling TCK edge, and TCK stays low while busy is low. A cmd_valid while busy is ignored.
- R12: done is a single-cycle pulse at the end of every command. rx_data is loaded in that same cycle and holds its value until the next done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_div | input | DIV_W | TCK half-period in system clocks (minimum 2) |
| cmd_valid | input | 1 | Command strobe, accepted when busy is low |
| cmd_op | input | 2 | 0 shift, 1 TAP reset, 2 goto Shift-IR, 3 goto Shift-DR |
| cmd_data | input | DATA_W | Word to send |
| cmd_len_m1 | input | $clog2(DATA_W) | Bit count minus one |
| cmd_msb_first | input | 1 | 1 sends the highest used bit first |
| cmd_exit | input | 1 | 1 raises TMS on the last data bit |
| cmd_to_idle | input | 1 | 1 continues to Run-Test/Idle after exit |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle end-of-command pulse |
| rx_data | output | DATA_W | Captured TDO word |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Test data to the target |
| tdo | input | 1 | Test data from the target |

## Verification
A wrong step counter or a wrong TMS pattern drives the target TAP into a wrong state. It shows within one command, as a wrong final state or a wrong TCK or TMS-high count, in a model TAP run in the bench. A wrong bit index shows in that same transfer as a mismatch between the bits the model received and the word sent, or as a misplaced bit in rx_data. Divider faults show in the measured TCK high time. Commands issued while busy must leave the running transfer's results unchanged.

// File: rtl/jsm_pkg.sv
package jsm_pkg;

   typedef enum logic [1:0] {
      OP_SHIFT   = 2'd0,
      OP_RESET   = 2'd1,
      OP_GOTO_IR = 2'd2,
      OP_GOTO_DR = 2'd3
   } jsm_op_e;

   typedef struct packed {
      jsm_op_e op;
      logic    msb_first;
      logic    exit_last;
      logic    to_idle;
   } jsm_flags_t;

endpackage

// File: rtl/jsm_tick.sv
module jsm_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] half,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;

   assign tick = run && (cnt_q == half - DIV_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt_q <= '0;
      else if (!run || tick) cnt_q <= '0;
      else                   cnt_q <= cnt_q + DIV_W'(1);
   end
endmodule

// File: rtl/jsm_pattern.sv
module jsm_pattern
   import jsm_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int RESET_ONES = 5,
   parameter int CNT_W      = 5,
   parameter int STEP_W     = 6
) (
   input  jsm_flags_t        cfg,
   input  logic [CNT_W-1:0]  len_m1,
   input  logic [DATA_W-1:0] word,
   input  logic [STEP_W-1:0] step,
   output logic              tms_o,
   output logic              tdi_o,
   output logic              is_data,
   output logic [CNT_W-1:0]  bit_idx,
   output logic              is_last
);
   logic [STEP_W-1:0] nd;
   logic [STEP_W-1:0] extra;
   logic [CNT_W-1:0]  lo;

   assign nd      = STEP_W'(len_m1);
   assign lo      = step[CNT_W-1:0];
   assign bit_idx = cfg.msb_first ? (len_m1 - lo) : lo;
   assign tdi_o   = is_data & word[bit_idx];

   always_comb begin
      tms_o   = 1'b0;
      is_data = 1'b0;
      is_last = 1'b0;
      extra   = '0;
      case (cfg.op)
         OP_RESET: begin
            tms_o   = step < STEP_W'(RESET_ONES);
            is_last = step == STEP_W'(RESET_ONES);
         end
         OP_GOTO_IR: begin
            tms_o   = step < STEP_W'(2);
            is_last = step == STEP_W'(3);
         end
         OP_GOTO_DR: begin
            tms_o   = step == '0;
            is_last = step == STEP_W'(2);
         end
         default: begin
            if (cfg.exit_last) extra = cfg.to_idle ? STEP_W'(2) : STEP_W'(1);
            is_last = step == (nd + extra);
            if (step <= nd) begin
               is_data = 1'b1;
               tms_o   = cfg.exit_last && (step == nd);
            end else begin
               tms_o   = step == (nd + STEP_W'(1));
            end
         end
      endcase
   end
endmodule

// File: rtl/jsm_capture.sv
module jsm_capture #(
   parameter int DATA_W = 32,
   parameter int CNT_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              we,
   input  logic [CNT_W-1:0]  idx,
   input  logic              bit_i,
   output logic [DATA_W-1:0] word_nxt
);
   logic [DATA_W-1:0] word_q;

   for (genvar i = 0; i < DATA_W; i++) begin : g_lane
      logic hit;
      assign hit         = we && (idx == CNT_W'(i));
      assign word_nxt[i] = hit ? bit_i : word_q[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)   word_q[i] <= 1'b0;
         else if (clr) word_q[i] <= 1'b0;
         else if (hit) word_q[i] <= bit_i;
      end
   end
endmodule

// File: rtl/jtag_shift_master.sv
module jtag_shift_master
   import jsm_pkg::*;
#(
   parameter int DATA_W     = 32,
   parameter int DIV_W      = 8,
   parameter int MIN_HALF   = 2,
   parameter int RESET_ONES = 5
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [DIV_W-1:0]          half_div,
   input  logic                      cmd_valid,
   input  logic [1:0]                cmd_op,
   input  logic [DATA_W-1:0]         cmd_data,
   input  logic [$clog2(DATA_W)-1:0] cmd_len_m1,
   input  logic                      cmd_msb_first,
   input  logic                      cmd_exit,
   input  logic                      cmd_to_idle,
   output logic                      busy,
   output logic                      done,
   output logic [DATA_W-1:0]         rx_data,
   output logic                      tck,
   output logic                      tms,
   output logic                      tdi,
   input  logic                      tdo
);
   localparam int CNT_W     = $clog2(DATA_W);
   localparam int MAX_STEPS = (DATA_W + 2 > RESET_ONES + 1) ? DATA_W + 2 : RESET_ONES + 1;
   localparam int STEP_W    = $clog2(MAX_STEPS + 1);

   if (DATA_W < 2 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("DATA_W must be a power of two of at least 2");
   end
   if (MIN_HALF < 2 || MIN_HALF >= (1 << DIV_W)) begin : g_bad_half
      $error("MIN_HALF must be at least 2 and fit in DIV_W bits");
   end
   if (RESET_ONES < 5) begin : g_bad_reset
      $error("RESET_ONES must be at least 5");
   end

   jsm_flags_t        flags_q, cmd_flags, nx_flags;
   logic [CNT_W-1:0]  len_q, nx_len;
   logic [DATA_W-1:0] data_q, nx_data;
   logic [STEP_W-1:0] step_q, nx_step;
   logic [DIV_W-1:0]  half_q;
   logic              busy_q, done_q, tck_q, tms_q, tdi_q;
   logic [DATA_W-1:0] rx_q;
   logic              tick, accept;
   logic              cur_tms, cur_tdi, cur_data, cur_last;
   logic [CNT_W-1:0]  cur_idx;
   logic              nx_tms, nx_tdi, nx_isdata, nx_last;
   logic [CNT_W-1:0]  nx_idx;
   logic [DATA_W-1:0] cap_next;
   logic              cap_we;

   assign cmd_flags = '{op: jsm_op_e'(cmd_op), msb_first: cmd_msb_first,
                        exit_last: cmd_exit, to_idle: cmd_to_idle};
   assign accept    = cmd_valid && !busy_q;
   assign nx_flags  = busy_q ? flags_q : cmd_flags;
   assign nx_len    = busy_q ? len_q   : cmd_len_m1;
   assign nx_data   = busy_q ? data_q  : cmd_data;
   assign nx_step   = busy_q ? (step_q + STEP_W'(1)) : '0;
   assign cap_we    = busy_q && tick && tck_q && cur_data;

   jsm_tick #(.DIV_W(DIV_W)) u_tick (
      .clk(clk), .rst_n(rst_n), .run(busy_q), .half(half_q), .tick(tick)
   );

   jsm_pattern #(.DATA_W(DATA_W), .RESET_ONES(RESET_ONES), .CNT_W(CNT_W), .STEP_W(STEP_W)) u_cur (
      .cfg(flags_q), .len_m1(len_q), .word(data_q), .step(step_q),
      .tms_o(cur_tms), .tdi_o(cur_tdi), .is_data(cur_data), .bit_idx(cur_idx), .is_last(cur_last)
   );

   jsm_pattern #(.DATA_W(DATA_W), .RESET_ONES(RESET_ONES), .CNT_W(CNT_W), .STEP_W(STEP_W)) u_nxt (
      .cfg(nx_flags), .len_m1(nx_len), .word(nx_data), .step(nx_step),
      .tms_o(nx_tms), .tdi_o(nx_tdi), .is_data(nx_isdata), .bit_idx(nx_idx), .is_last(nx_last)
   );

   jsm_capture #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cap (
      .clk(clk), .rst_n(rst_n), .clr(accept), .we(cap_we),
      .idx(cur_idx), .bit_i(tdo), .word_nxt(cap_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         done_q  <= 1'b0;
         tck_q   <= 1'b0;
         tms_q   <= 1'b1;
         tdi_q   <= 1'b0;
         step_q  <= '0;
         rx_q    <= '0;
         flags_q <= '0;
         len_q   <= '0;
         data_q  <= '0;
         half_q  <= DIV_W'(MIN_HALF);
      end else begin
         done_q <= 1'b0;
         if (!busy_q) begin
            if (cmd_valid) begin
               flags_q <= cmd_flags;
               len_q   <= cmd_len_m1;
               data_q  <= cmd_data;
               half_q  <= (half_div < DIV_W'(MIN_HALF)) ? DIV_W'(MIN_HALF) : half_div;
               busy_q  <= 1'b1;
               step_q  <= '0;
               tms_q   <= nx_tms;
               tdi_q   <= nx_tdi;
            end
         end else if (tick) begin
            if (!tck_q) begin
               tck_q <= 1'b1;
            end else begin
               tck_q <= 1'b0;
               if (cur_last) begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
                  rx_q   <= cap_next;
               end else begin
                  step_q <= nx_step;
                  tms_q  <= nx_tms;
                  tdi_q  <= nx_tdi;
               end
            end
         end
      end
   end

   assign busy    = busy_q;
   assign done    = done_q;
   assign rx_data = rx_q;
   assign tck     = tck_q;
   assign tms     = tms_q;
   assign tdi     = tdi_q;

endmodule

// File: rtl/jsm_checker.sv
module jsm_checker #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cmd_valid,
   input logic              busy,
   input logic              done,
   input logic [DATA_W-1:0] rx_data,
   input logic              tck,
   input logic              tms,
   input logic              tdi
);
   // R9
   pins_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      tck |-> ($stable(tms) && $stable(tdi)));

   // R11
   idle_tck_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !tck);

   // R11
   accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !busy) |=> busy);

   // R11
   end_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> ($past(tck) && !tck));

   // R12
   done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R12
   done_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   // R12
   rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |-> $stable(rx_data));
endmodule

bind jtag_shift_master jsm_checker #(.DATA_W(DATA_W)) u_jsm_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .busy(busy), .done(done),
   .rx_data(rx_data), .tck(tck), .tms(tms), .tdi(tdi)
);

// File: tb/jtag_shift_master_test.sv
module jtag_shift_master_test;
   typedef enum logic [3:0] {
      T_TLR, T_IDLE, T_SELDR, T_CAPDR, T_SHDR, T_EX1DR, T_PAUDR, T_EX2DR, T_UPDDR,
      T_SELIR, T_CAPIR, T_SHIR, T_EX1IR, T_PAUIR, T_EX2IR, T_UPDIR
   } tap_e;

   localparam logic [63:0] CAP_DR = 64'hC3A5_5A3C_F00F_1E2D;
   localparam logic [63:0] CAP_IR = 64'h0F1E_2D3C_8421_7BD6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  half_div = 8'd2;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_op = 2'd0;
   logic [31:0] cmd_data = '0;
   logic [4:0]  cmd_len_m1 = '0;
   logic        cmd_msb_first = 1'b0, cmd_exit = 1'b0, cmd_to_idle = 1'b0;
   logic        busy, done, tck, tms, tdi;
   logic [31:0] rx_data;
   logic        tdo = 1'b0;

   int checks = 0;
   int fails = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   jtag_shift_master uut (
      .clk(clk), .rst_n(rst_n), .half_div(half_div), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_data(cmd_data), .cmd_len_m1(cmd_len_m1), .cmd_msb_first(cmd_msb_first),
      .cmd_exit(cmd_exit), .cmd_to_idle(cmd_to_idle), .busy(busy), .done(done),
      .rx_data(rx_data), .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo)
   );

   // model target TAP
   tap_e        tap = T_TLR;
   logic [63:0] sr = '0;
   logic [63:0] rcv_log = '0;
   int          rcv_cnt = 0, edge_cnt = 0, tms_hi = 0;

   function automatic tap_e tap_next(tap_e s, logic m);
      case (s)
         T_TLR:   return m ? T_TLR   : T_IDLE;
         T_IDLE:  return m ? T_SELDR : T_IDLE;
         T_SELDR: return m ? T_SELIR : T_CAPDR;
         T_CAPDR: return m ? T_EX1DR : T_SHDR;
         T_SHDR:  return m ? T_EX1DR : T_SHDR;
         T_EX1DR: return m ? T_UPDDR : T_PAUDR;
         T_PAUDR: return m ? T_EX2DR : T_PAUDR;
         T_EX2DR: return m ? T_UPDDR : T_SHDR;
         T_UPDDR: return m ? T_SELDR : T_IDLE;
         T_SELIR: return m ? T_TLR   : T_CAPIR;
         T_CAPIR: return m ? T_EX1IR : T_SHIR;
         T_SHIR:  return m ? T_EX1IR : T_SHIR;
         T_EX1IR: return m ? T_UPDIR : T_PAUIR;
         T_PAUIR: return m ? T_EX2IR : T_PAUIR;
         T_EX2IR: return m ? T_UPDIR : T_SHIR;
         default: return m ? T_SELDR : T_IDLE;
      endcase
   endfunction

   always @(posedge tck) begin
      if (tap == T_CAPDR) sr <= CAP_DR;
      else if (tap == T_CAPIR) sr <= CAP_IR;
      else if (tap == T_SHDR || tap == T_SHIR) begin
         sr <= {tdi, sr[63:1]};
         rcv_log[rcv_cnt % 64] <= tdi;
         rcv_cnt <= rcv_cnt + 1;
      end
      if (tms) tms_hi <= tms_hi + 1;
      edge_cnt <= edge_cnt + 1;
      tap <= tap_next(tap, tms);
   end

   always @(negedge tck) tdo <= sr[0];

   // TCK high-time measurement
   logic tck_d = 1'b0;
   int   run_len = 0, last_hi = 0;
   always @(posedge clk) begin
      tck_d <= tck;
      if (tck != tck_d) run_len <= 1; else run_len <= run_len + 1;
      if (tck_d && !tck) last_hi <= run_len;
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   int s_edge, s_tms, s_rcv;

   task automatic do_cmd(input logic [1:0] op, input logic [31:0] d, input int n,
                         input logic msb, input logic ex, input logic idl, input bit poke);
      while (busy) @(negedge clk);
      s_edge = edge_cnt; s_tms = tms_hi; s_rcv = rcv_cnt;
      cmd_op = op; cmd_data = d; cmd_len_m1 = 5'(n - 1);
      cmd_msb_first = msb; cmd_exit = ex; cmd_to_idle = idl;
      cmd_valid = 1'b1;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk("R11 busy after accept", 64'(busy), 64'd1);
      if (poke) begin
         repeat (3) @(negedge clk);
         cmd_op = 2'd1; cmd_data = ~d; cmd_valid = 1'b1;
         @(negedge clk);
         cmd_valid = 1'b0;
      end
      while (!done) @(negedge clk);
   endtask

   task automatic shift_case(input int n, input logic msb, input logic ex, input logic idl,
                             input bit ir, input logic [31:0] d, input int half_exp, input bit poke);
      logic [31:0] exp_rx, got_tdi, exp_tdi;
      logic [63:0] cap;
      tap_e        exp_st;
      int          extra;
      do_cmd(2'd1, '0, 1, 0, 0, 0, 0);
      chk("R2 reset edges", 64'(edge_cnt - s_edge), 64'd6);
      chk("R2 reset tms high", 64'(tms_hi - s_tms), 64'd5);
      chk("R2 reset idle", 64'(tap), 64'(T_IDLE));
      do_cmd(ir ? 2'd2 : 2'd3, '0, 1, 0, 0, 0, 0);
      chk("R3 goto edges", 64'(edge_cnt - s_edge), ir ? 64'd4 : 64'd3);
      chk("R3 goto state", 64'(tap), ir ? 64'(T_SHIR) : 64'(T_SHDR));
      do_cmd(2'd0, d, n, msb, ex, idl, poke);
      cap = ir ? CAP_IR : CAP_DR;
      exp_rx = '0; got_tdi = '0; exp_tdi = '0;
      for (int i = 0; i < n; i++) begin
         exp_rx[msb ? n - 1 - i : i] = cap[i];
         got_tdi[i] = rcv_log[(s_rcv + i) % 64];
         exp_tdi[i] = d[msb ? n - 1 - i : i];
      end
      chk("R6 rx packing", 64'(rx_data), 64'(exp_rx));
      chk(msb ? "R5 msb tdi order" : "R4 lsb tdi order", 64'(got_tdi), 64'(exp_tdi));
      chk("R4 data bit count", 64'(rcv_cnt - s_rcv), 64'(n));
      extra  = ex ? (idl ? 2 : 1) : 0;
      chk("R8 total edges", 64'(edge_cnt - s_edge), 64'(n + extra));
      chk("R7 tms high count", 64'(tms_hi - s_tms), ex ? 64'd2 : 64'd0);
      exp_st = !ex ? (ir ? T_SHIR : T_SHDR) : idl ? T_IDLE : (ir ? T_UPDIR : T_UPDDR);
      chk("R8 end state", 64'(tap), 64'(exp_st));
      chk("R10 tck high time", 64'(last_hi), 64'(half_exp));
   endtask

   initial begin
      logic [31:0] d1;
      logic [31:0] exp_rx2;
      repeat (3) @(negedge clk);
      chk("R1 tck", 64'(tck), 64'd0);
      chk("R1 tms", 64'(tms), 64'd1);
      chk("R1 tdi busy done", 64'({tdi, busy, done}), 64'd0);
      chk("R1 rx_data", 64'(rx_data), 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      // sweep over all lengths and both orders
      for (int n = 1; n <= 32; n++) begin
         for (int m = 0; m < 2; m++) begin
            d1 = (32'h9E37_79B9 * n) ^ 32'h5A5A_0F0F ^ (m != 0 ? 32'hFFFF_0000 : 32'h0);
            case (n % 3)
               0: shift_case(n, m[0], 1'b1, 1'b1, (n % 4) == 3, d1, 2, 0);
               1: shift_case(n, m[0], 1'b1, 1'b0, (n % 4) == 3, d1, 2, 0);
               default: shift_case(n, m[0], 1'b0, 1'b1, (n % 4) == 3, d1, 2, 0); // R7 idle ignored
            endcase
         end
      end

      // R2 reset from Shift-DR
      do_cmd(2'd1, '0, 1, 0, 0, 0, 0);
      chk("R2 reset from shift", 64'(tap), 64'(T_IDLE));

      // chained transfer: 20 bits no exit, then 12 bits exit to idle (R7, R8)
      do_cmd(2'd3, '0, 1, 0, 0, 0, 0);
      do_cmd(2'd0, 32'h000A_BCDE, 20, 0, 0, 0, 0);
      chk("R7 chain stays shift", 64'(tap), 64'(T_SHDR));
      chk("R6 chain first part", 64'(rx_data), 64'(CAP_DR[19:0]));
      do_cmd(2'd0, 32'h0000_0F5A, 12, 0, 1, 1, 0);
      exp_rx2 = 32'(CAP_DR[31:20]);
      chk("R6 chain second part", 64'(rx_data), 64'(exp_rx2));
      chk("R8 chain idle", 64'(tap), 64'(T_IDLE));

      // R10 divider settings, R11 command while busy ignored
      half_div = 8'd5;
      shift_case(17, 1'b1, 1'b1, 1'b1, 0, 32'h1357_9BDF, 5, 1);
      half_div = 8'd0;
      shift_case(9, 1'b0, 1'b1, 1'b1, 1, 32'h0000_01A5, 2, 0);
      half_div = 8'd1;
      shift_case(32, 1'b0, 1'b1, 1'b0, 0, 32'hDEAD_BEEF, 2, 1);
      half_div = 8'd3;
      shift_case(1, 1'b1, 1'b1, 1'b1, 1, 32'h0000_0001, 3, 0);

      // R12 done is one cycle, rx holds
      @(negedge clk);
      chk("R12 done dropped", 64'(done), 64'd0);
      chk("R12 idle tck", 64'(tck), 64'd0);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         checks++;
         fails++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end
endmodule